// File: doc/BRIEF.md
# Acquisition Start Trigger Controller

This block decides the moment at which converted samples are allowed into the acquisition data FIFO. Software programs a trigger word that picks the start mode and the start source, then either issues a start write or lets a rising edge on an external trigger pin begin the run. From then on, every sample strobe coming from the channel scanner is either passed to the FIFO write side or dropped, depending on the controller state.

Two start modes exist. In the immediate mode, capture opens on the cycle after the trigger. In the hold-off mode, the controller first lets a programmable number of sample periods go by without writing them (72 after reset), so that the samples taken while the sampling clock settles after a rate change never reach the FIFO. A FIFO reset write returns the controller to idle from any state and emits a one-cycle clear pulse toward the FIFO. An optional hardware sample count can end a run by itself. It is off after reset, so that a run continues until software stops it.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After reset, `ctl_state` is 0 (idle), `capture_en`, `sample_wr` and `fifo_clr` are low, and the hold-off length is 72 sample strobes.
- R2: A trigger word write whose bits [1:0] equal 2 (immediate) or 3 (hold-off) puts the controller in the armed state (`ctl_state` 1) at the next clock edge, whatever state it was in. Any other value in bits [1:0] returns it to idle.
- R3: A start write while idle (or while a run is in hold-off or capture) has no effect on the state. A trigger is acted on only in the armed state.
- R4: With the trigger word's bit 4 clear, a start write in the armed state in immediate mode gives capture (`ctl_state` 3, `capture_en` high) at the next edge. While capturing, `sample_wr` equals `sample_stb`. In every other state, `sample_wr` is low.
- R5: With bit 4 set, only a rising edge of `ext_trig` starts the run, with a three-edge latency from the pin through a two-flop synchronizer and an edge detector. Start writes are ignored. A level that is already high when arming gives no trigger. With bit 4 clear, edges on `ext_trig` are ignored.
- R6: In hold-off mode, a trigger moves the controller to hold-off (`ctl_state` 2). The next N sample strobes are discarded (`sample_wr` low). Capture begins at the edge of the N-th strobe, so the strobe after it is the first one written. Cycles without a strobe do not advance the count.
- R7: A hold-off length write stores `dly_val` as the new N, used from the next trigger on. N = 0 makes hold-off mode behave like immediate mode.
- R8: A FIFO reset write returns the controller to idle at the next edge from any state, and takes priority over a trigger word write, a start write or a strobe in the same cycle. `fifo_clr` is high for exactly the one cycle after that edge. The stored trigger word, hold-off length and stop settings are kept.
- R9: A stop write stores `stop_en` and `stop_val`. While `stop_en` is 0, capture never ends by itself. While it is 1 with `stop_val` = M ≥ 1, the controller returns to idle at the edge of the M-th written sample of the run.
- R10: `ctl_state` encodes idle = 0, armed = 1, hold-off = 2, capture = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_cfg_wr | input | 1 | Trigger word write strobe |
| trig_cfg_data | input | CFG_W | Trigger word: [1:0] mode, [4] external source enable |
| start_wr | input | 1 | Software start write strobe |
| fifo_rst_wr | input | 1 | FIFO and trigger reset write strobe |
| ext_trig | input | 1 | Asynchronous external start trigger |
| dly_wr | input | 1 | Hold-off length write strobe |
| dly_val | input | DLY_W | Hold-off length in sample strobes |
| stop_wr | input | 1 | Hardware stop count write strobe |
| stop_en | input | 1 | Enable the hardware stop count |
| stop_val | input | CNT_W | Number of samples after which capture ends |
| sample_stb | input | 1 | One-cycle strobe per converted sample |
| capture_en | output | 1 | High while the controller is capturing |
| sample_wr | output | 1 | FIFO write enable for the current sample |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| ctl_state | output | 2 | Current controller state |

## Verification
The bench keeps the reset hold-off length of 72 and the two-stage synchronizer, so a directed hold-off run walks through the full default window, including its last discarded strobe and its first written one. The stop counter is narrowed to 6 bits, and random runs load hold-off lengths of 0 to 5 and stop counts of 1 to 8. Trigger, stop, re-arm and FIFO-reset events therefore happen often enough that collisions among them, such as a reset in the same cycle as a re-arm, or an external edge while the controller is not armed, come up many times within a short run.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_DELAY   = 2'd2,
        ST_CAPTURE = 2'd3
    } trig_state_e;

    localparam int          MODE_W     = 2;
    localparam logic [1:0]  MODE_POST  = 2'd2;
    localparam logic [1:0]  MODE_DELAY = 2'd3;
    localparam int          EXT_EN_POS = 4;

    function automatic logic mode_arms(input logic [MODE_W-1:0] m);
        return (m == MODE_POST) || (m == MODE_DELAY);
    endfunction

endpackage

// File: rtl/acq_trig_sync.sv
module acq_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LAST-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[LAST-1] & ~sh_q[LAST];

endmodule

// File: rtl/acq_trig_cfg.sv
module acq_trig_cfg
    import acq_trig_pkg::*;
#(
    parameter int CFG_W       = 8,
    parameter int DLY_W       = 8,
    parameter int CNT_W       = 16,
    parameter int DLY_DEFAULT = 72
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_cfg_wr,
    input  logic [CFG_W-1:0] trig_cfg_data,
    input  logic             dly_wr,
    input  logic [DLY_W-1:0] dly_val,
    input  logic             stop_wr,
    input  logic             stop_en,
    input  logic [CNT_W-1:0] stop_val,
    output logic [MODE_W-1:0] mode_q,
    output logic             ext_en_q,
    output logic [DLY_W-1:0] dly_q,
    output logic             stop_en_q,
    output logic [CNT_W-1:0] stop_val_q
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              ext_en;
        logic [DLY_W-1:0]  dly;
        logic              sen;
        logic [CNT_W-1:0]  sval;
    } cfg_t;

    cfg_t c_d, c_q;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^trig_cfg_data;

    always_comb begin
        c_d = c_q;
        if (trig_cfg_wr) begin
            c_d.mode   = trig_cfg_data[MODE_W-1:0];
            c_d.ext_en = trig_cfg_data[EXT_EN_POS];
        end
        if (dly_wr) begin
            c_d.dly = dly_val;
        end
        if (stop_wr) begin
            c_d.sen  = stop_en;
            c_d.sval = stop_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.mode   <= '0;
            c_q.ext_en <= 1'b0;
            c_q.dly    <= DLY_W'(DLY_DEFAULT);
            c_q.sen    <= 1'b0;
            c_q.sval   <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mode_q     = c_q.mode;
    assign ext_en_q   = c_q.ext_en;
    assign dly_q      = c_q.dly;
    assign stop_en_q  = c_q.sen;
    assign stop_val_q = c_q.sval;

endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
    import acq_trig_pkg::*;
#(
    parameter int CFG_W       = 8,
    parameter int DLY_W       = 8,
    parameter int CNT_W       = 16,
    parameter int DLY_DEFAULT = 72,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_cfg_wr,
    input  logic [CFG_W-1:0] trig_cfg_data,
    input  logic             start_wr,
    input  logic             fifo_rst_wr,
    input  logic             ext_trig,
    input  logic             dly_wr,
    input  logic [DLY_W-1:0] dly_val,
    input  logic             stop_wr,
    input  logic             stop_en,
    input  logic [CNT_W-1:0] stop_val,
    input  logic             sample_stb,
    output logic             capture_en,
    output logic             sample_wr,
    output logic             fifo_clr,
    output logic [1:0]       ctl_state
);
    logic              ext_rise;
    logic [MODE_W-1:0] mode_q;
    logic              ext_en_q;
    logic [DLY_W-1:0]  dly_q;
    logic              stop_en_q;
    logic [CNT_W-1:0]  stop_val_q;
    logic              fire;

    acq_trig_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_trig),
        .rise  (ext_rise)
    );

    acq_trig_cfg #(
        .CFG_W       (CFG_W),
        .DLY_W       (DLY_W),
        .CNT_W       (CNT_W),
        .DLY_DEFAULT (DLY_DEFAULT)
    ) cfg_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_cfg_wr   (trig_cfg_wr),
        .trig_cfg_data (trig_cfg_data),
        .dly_wr        (dly_wr),
        .dly_val       (dly_val),
        .stop_wr       (stop_wr),
        .stop_en       (stop_en),
        .stop_val      (stop_val),
        .mode_q        (mode_q),
        .ext_en_q      (ext_en_q),
        .dly_q         (dly_q),
        .stop_en_q     (stop_en_q),
        .stop_val_q    (stop_val_q)
    );

    typedef struct packed {
        trig_state_e      st;
        logic [DLY_W-1:0] dcnt;
        logic [CNT_W-1:0] ccnt;
        logic             clr;
    } ctl_t;

    ctl_t r_d, r_q;

    assign fire = ext_en_q ? ext_rise : start_wr;

    always_comb begin
        r_d     = r_q;
        r_d.clr = fifo_rst_wr;
        if (fifo_rst_wr) begin
            r_d.st = ST_IDLE;
        end else if (trig_cfg_wr) begin
            r_d.st = mode_arms(trig_cfg_data[MODE_W-1:0]) ? ST_ARMED : ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.st = ST_IDLE;
                end
                ST_ARMED: begin
                    if (fire) begin
                        if (mode_q == MODE_DELAY && dly_q != '0) begin
                            r_d.st   = ST_DELAY;
                            r_d.dcnt = dly_q;
                        end else begin
                            r_d.st   = ST_CAPTURE;
                            r_d.ccnt = '0;
                        end
                    end
                end
                ST_DELAY: begin
                    if (sample_stb) begin
                        r_d.dcnt = r_q.dcnt - 1'b1;
                        if (r_q.dcnt <= DLY_W'(1)) begin
                            r_d.st   = ST_CAPTURE;
                            r_d.ccnt = '0;
                        end
                    end
                end
                ST_CAPTURE: begin
                    if (sample_stb && stop_en_q) begin
                        r_d.ccnt = r_q.ccnt + 1'b1;
                        if (CNT_W'(r_q.ccnt + 1'b1) == stop_val_q) begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.dcnt <= '0;
            r_q.ccnt <= '0;
            r_q.clr  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign capture_en = (r_q.st == ST_CAPTURE);
    assign sample_wr  = capture_en & sample_stb;
    assign fifo_clr   = r_q.clr;
    assign ctl_state  = r_q.st;

endmodule

// File: rtl/acq_trig_ctrl_chk.sv
module acq_trig_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_cfg_wr,
    input logic [1:0] cfg_mode,
    input logic       fifo_rst_wr,
    input logic       sample_stb,
    input logic       capture_en,
    input logic       sample_wr,
    input logic       fifo_clr,
    input logic [1:0] ctl_state
);
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst_wr |=> (ctl_state == 2'd0) && fifo_clr); // R8

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rst_wr |=> !fifo_clr); // R8

    AST_CFG_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_cfg_wr && !fifo_rst_wr && (cfg_mode == 2'd2 || cfg_mode == 2'd3))
        |=> (ctl_state == 2'd1)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == 2'd0 && !trig_cfg_wr) |=> (ctl_state == 2'd0)); // R3

    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        sample_wr |-> (capture_en && sample_stb)); // R4

    AST_DELAY_WAITS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == 2'd2 && !sample_stb && !trig_cfg_wr && !fifo_rst_wr)
        |=> (ctl_state == 2'd2)); // R6

endmodule

bind acq_trig_ctrl acq_trig_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_cfg_wr (trig_cfg_wr),
    .cfg_mode    (trig_cfg_data[1:0]),
    .fifo_rst_wr (fifo_rst_wr),
    .sample_stb  (sample_stb),
    .capture_en  (capture_en),
    .sample_wr   (sample_wr),
    .fifo_clr    (fifo_clr),
    .ctl_state   (ctl_state)
);

// File: tb/acq_trig_ctrl_tb_top.sv
`timescale 1ns/1ps
module acq_trig_ctrl_tb_top;
    localparam int CFG_W = 8;
    localparam int DLY_W = 8;
    localparam int CNT_W = 6;
    localparam int DLY_DEF = 72;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_cfg_wr = 1'b0;
    logic [CFG_W-1:0] trig_cfg_data = '0;
    logic             start_wr = 1'b0;
    logic             fifo_rst_wr = 1'b0;
    logic             ext_trig = 1'b0;
    logic             dly_wr = 1'b0;
    logic [DLY_W-1:0] dly_val = '0;
    logic             stop_wr = 1'b0;
    logic             stop_en = 1'b0;
    logic [CNT_W-1:0] stop_val = '0;
    logic             sample_stb = 1'b0;
    logic             capture_en, sample_wr, fifo_clr;
    logic [1:0]       ctl_state;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench-side reference state
    int m_st, m_dcnt, m_ccnt, m_mode, m_dly, m_sval;
    bit m_clr, m_ext, m_sen, m_s1, m_s2, m_s3;

    always #5 clk = ~clk;

    acq_trig_ctrl #(
        .CFG_W(CFG_W), .DLY_W(DLY_W), .CNT_W(CNT_W),
        .DLY_DEFAULT(DLY_DEF), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_cfg_wr(trig_cfg_wr),
        .trig_cfg_data(trig_cfg_data), .start_wr(start_wr),
        .fifo_rst_wr(fifo_rst_wr), .ext_trig(ext_trig), .dly_wr(dly_wr),
        .dly_val(dly_val), .stop_wr(stop_wr), .stop_en(stop_en),
        .stop_val(stop_val), .sample_stb(sample_stb),
        .capture_en(capture_en), .sample_wr(sample_wr),
        .fifo_clr(fifo_clr), .ctl_state(ctl_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit arms(input int m);
        return (m == 2) || (m == 3);
    endfunction

    task automatic model_reset();
        m_st = 0; m_dcnt = 0; m_ccnt = 0; m_mode = 0; m_dly = DLY_DEF;
        m_sval = 0; m_clr = 0; m_ext = 0; m_sen = 0;
        m_s1 = 0; m_s2 = 0; m_s3 = 0;
    endtask

    // one clock edge of the reference, using the inputs held at that edge
    task automatic model_edge();
        bit rise;
        bit fire;
        int nst;
        rise = m_s2 && !m_s3;
        fire = m_ext ? rise : start_wr;
        nst = m_st;
        if (fifo_rst_wr) nst = 0;
        else if (trig_cfg_wr) nst = arms(int'(trig_cfg_data[1:0])) ? 1 : 0;
        else begin
            case (m_st)
                1: if (fire) begin
                    if (m_mode == 3 && m_dly != 0) begin nst = 2; m_dcnt = m_dly; end
                    else begin nst = 3; m_ccnt = 0; end
                end
                2: if (sample_stb) begin
                    if (m_dcnt <= 1) begin nst = 3; m_ccnt = 0; end
                    m_dcnt = m_dcnt - 1;
                end
                3: if (sample_stb && m_sen) begin
                    m_ccnt = (m_ccnt + 1) % (1 << CNT_W);
                    if (m_ccnt == m_sval) nst = 0;
                end
                default: ;
            endcase
        end
        m_st = nst;
        m_clr = fifo_rst_wr;
        if (trig_cfg_wr) begin m_mode = int'(trig_cfg_data[1:0]); m_ext = trig_cfg_data[4]; end
        if (dly_wr) m_dly = int'(dly_val);
        if (stop_wr) begin m_sen = stop_en; m_sval = int'(stop_val); end
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_trig;
    endtask

    task automatic clk1();
        @(posedge clk);
        #1;
        model_edge();
        trig_cfg_wr = 0; start_wr = 0; fifo_rst_wr = 0; dly_wr = 0; stop_wr = 0;
        #1;
        chk("R10 state vs model", int'(ctl_state), m_st);
        chk("R4 capture_en vs model", int'(capture_en), int'(m_st == 3));
        chk("R8 fifo_clr vs model", int'(fifo_clr), int'(m_clr));
    endtask

    task automatic cfg(input logic [CFG_W-1:0] w);
        trig_cfg_wr = 1; trig_cfg_data = w;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R1 reset state", int'(ctl_state), 0);
        chk("R1 reset capture_en", int'(capture_en), 0);
        chk("R1 reset fifo_clr", int'(fifo_clr), 0);
        sample_stb = 1; #1;
        chk("R1 reset sample_wr", int'(sample_wr), 0);
        sample_stb = 0;

        // R3: start while idle ignored
        start_wr = 1; clk1();
        chk("R3 start in idle", int'(ctl_state), 0);

        // R2: arm and disarm by mode field
        cfg(8'h02); clk1();
        chk("R2 mode 2 arms", int'(ctl_state), 1);
        cfg(8'h01); clk1();
        chk("R2 mode 1 idles", int'(ctl_state), 0);
        cfg(8'h02); clk1();

        // R5: external edge ignored while bit 4 clear
        ext_trig = 1; repeat (4) clk1();
        chk("R5 ext ignored when disabled", int'(ctl_state), 1);
        ext_trig = 0; repeat (3) clk1();

        // R4: immediate start
        start_wr = 1; clk1();
        chk("R4 post start", int'(ctl_state), 3);
        sample_stb = 1; #1;
        chk("R4 sample_wr follows strobe", int'(sample_wr), 1);
        sample_stb = 0; #1;
        chk("R4 no strobe no write", int'(sample_wr), 0);
        sample_stb = 1; repeat (20) clk1();
        chk("R9 no stop when disabled", int'(ctl_state), 3);

        // R8: reset beats a simultaneous re-arm
        fifo_rst_wr = 1; cfg(8'h02); start_wr = 1; clk1();
        chk("R8 reset to idle", int'(ctl_state), 0);
        chk("R8 clear pulse", int'(fifo_clr), 1);
        sample_stb = 0; clk1();
        chk("R8 clear one cycle", int'(fifo_clr), 0);

        // R6: default hold-off of 72 strobes
        cfg(8'h03); clk1();
        start_wr = 1; clk1();
        chk("R6 enter hold-off", int'(ctl_state), 2);
        clk1(); clk1();
        chk("R6 no strobe no progress", int'(ctl_state), 2);
        sample_stb = 1;
        for (int i = 0; i < 71; i++) begin
            #1 chk("R6 discarded sample", int'(sample_wr), 0);
            clk1();
        end
        chk("R6 still holding after 71", int'(ctl_state), 2);
        clk1();
        chk("R6 capture after 72", int'(ctl_state), 3);
        #1 chk("R6 first written sample", int'(sample_wr), 1);
        sample_stb = 0;
        fifo_rst_wr = 1; clk1();

        // R5: external source
        cfg(8'h12); clk1();
        start_wr = 1; clk1();
        chk("R5 start ignored with ext", int'(ctl_state), 1);
        ext_trig = 1; clk1(); clk1();
        chk("R5 sync latency", int'(ctl_state), 1);
        clk1();
        chk("R5 ext edge starts", int'(ctl_state), 3);
        fifo_rst_wr = 1; clk1();
        cfg(8'h12); clk1();
        repeat (4) clk1();
        chk("R5 held level no trigger", int'(ctl_state), 1);
        ext_trig = 0; fifo_rst_wr = 1; clk1();

        // R7: hold-off length loads
        dly_wr = 1; dly_val = 0; cfg(8'h03); clk1();
        start_wr = 1; clk1();
        chk("R7 zero length capture", int'(ctl_state), 3);
        fifo_rst_wr = 1; clk1();
        dly_wr = 1; dly_val = 3; cfg(8'h03); clk1();
        start_wr = 1; clk1();
        sample_stb = 1; clk1(); clk1();
        chk("R7 length 3 holding", int'(ctl_state), 2);
        clk1();
        chk("R7 length 3 capture", int'(ctl_state), 3);
        sample_stb = 0; fifo_rst_wr = 1; clk1();

        // R9: stop after 4 written samples
        stop_wr = 1; stop_en = 1; stop_val = 4; cfg(8'h02); clk1();
        start_wr = 1; clk1();
        sample_stb = 1;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R9 writing", int'(sample_wr), 1);
            clk1();
        end
        chk("R9 running before limit", int'(ctl_state), 3);
        clk1();
        chk("R9 stop at limit", int'(ctl_state), 0);
        sample_stb = 0;

        // random mix against the bench reference
        void'($urandom(32'h5EED_7A11));
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 100 < 6) begin
                trig_cfg_wr = 1;
                trig_cfg_data = '0;
                trig_cfg_data[1:0] = ($urandom % 10 < 7) ? 2'(2 + $urandom % 2) : 2'($urandom % 4);
                trig_cfg_data[4] = 1'($urandom % 2);
            end
            start_wr    = ($urandom % 8) == 0;
            fifo_rst_wr = ($urandom % 60) == 0;
            if ($urandom % 5 == 0) ext_trig = ~ext_trig;
            if ($urandom % 40 == 0) begin dly_wr = 1; dly_val = DLY_W'($urandom % 6); end
            if ($urandom % 50 == 0) begin
                stop_wr = 1; stop_en = 1'($urandom % 2); stop_val = CNT_W'(1 + $urandom % 8);
            end
            sample_stb = 1'($urandom % 2);
            #1 chk("R4 sample_wr vs model", int'(sample_wr), int'(m_st == 3 && sample_stb));
            clk1();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule